// File: doc/BRIEF.md
# Privilege Mode Transition Controller

This block keeps the privilege level of a small processor core, either user or supervisor, and manages the moves between the two levels. A system-call strobe sends the fetch address to a fixed supervisor entry point. It also records the interrupted program counter and the level that was running, and it raises the core to supervisor. A return strobe sends fetch back to the recorded address and reinstates the recorded level. Only one level of trap state is held, so a second system call overwrites the first.

The block also owns the privileged control state: the level bit, an exception-enable bit and a protection-control field. Supervisor code can write these through a small write port. In user mode the hardware refuses such writes and reports each refused write with a one-cycle violation flag. When no trap event is present, the next-PC output is the current PC plus one instruction width.

Top module: `priv_mode_ctrl`

## Requirements
- R1: In a cycle with `sys_call` high, `next_pc` equals the parameter `ENTRY_ADDR` (0x0000_0100 by default), combinationally in that cycle.
- R2: A system call stores `pc_in` of its cycle as the return address. A later return presents that value on `next_pc`.
- R3: The clock edge that ends a system-call cycle sets `cur_mode` to supervisor (1; user is 0). A system call made in supervisor mode still stores the PC and the level. Only the latest call is kept.
- R4: In a cycle with `trap_ret` high and `sys_call` low, `next_pc` equals the stored return address. At the following edge, `cur_mode` takes the stored level.
- R5: In user mode, a privileged write (`pw_valid` high) leaves `cur_mode`, `exc_en` and `prot_ctrl` unchanged.
- R6: Each refused user-mode write, made without a trap strobe in the same cycle, raises `priv_viol` for exactly the one cycle after it. No other condition raises `priv_viol`.
- R7: While `rst_n` is sampled low, the block returns to supervisor mode, with `exc_en` 0, `prot_ctrl` 0, stored return address 0 and stored level user.
- R8: When `sys_call` and `trap_ret` are both high, the system call wins. `next_pc` is `ENTRY_ADDR` and the trap state is saved.
- R9: In supervisor mode, with no trap strobe, a write takes effect at the next edge. Selector 0 writes the level from `pw_data[0]`, selector 1 writes `exc_en` from `pw_data[0]`, selector 2 writes `prot_ctrl` from all of `pw_data`, and selector 3 changes nothing.
- R10: Without a trap strobe, `next_pc` is `pc_in + 4`. A privileged write in the same cycle as a trap strobe is dropped without a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_in | input | PC_W | PC of the instruction in this cycle |
| sys_call | input | 1 | System-call strobe |
| trap_ret | input | 1 | Return-from-trap strobe |
| pw_valid | input | 1 | Privileged write request |
| pw_sel | input | 2 | Privileged write target selector |
| pw_data | input | PROT_W | Privileged write data |
| next_pc | output | PC_W | Fetch address for the next cycle |
| cur_mode | output | 1 | Current level, 1 = supervisor |
| exc_en | output | 1 | Exception enable |
| prot_ctrl | output | PROT_W | Protection control field |
| priv_viol | output | 1 | Refused privileged write, one-cycle pulse |

## Verification
The bench goes after four corner cases:
- A nested system call from supervisor mode. A design that kept the first return address, or did not save the supervisor level, would return to user code at the wrong place.
- A cycle with both strobes high. A design that let the return win would leave through the old return address.
- User-mode writes to each target. A design that only gated some targets would let the exception bit or the protection field change.
- A write that arrives together with a trap strobe. A design that flagged it or applied it would show a spurious violation or a changed level.

The last check is a return right after a mid-run reset, which shows whether the stored address and level were cleared to zero and user.

// File: rtl/priv_pkg.sv
// Package priv_pkg
// Shared encodings for the privilege controller: the level encoding and the
// privileged-write target selector. Assumes the selector is two bits wide.
package priv_pkg;

    typedef enum logic {
        LVL_USER = 1'b0,
        LVL_SUP  = 1'b1
    } priv_lvl_e;

    typedef enum logic [1:0] {
        TGT_LEVEL = 2'd0,
        TGT_EXC   = 2'd1,
        TGT_PROT  = 2'd2,
        TGT_NONE  = 2'd3
    } pw_tgt_e;

endpackage

// File: rtl/pmc_trap_unit.sv
// Module pmc_trap_unit
// Holds the current level, the single stored return address and the stored
// level. Chooses the fetch address. Assumes sys_call takes priority over
// trap_ret and that a level write arrives only when no strobe is present.
module pmc_trap_unit
    import priv_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter logic [31:0] ENTRY_ADDR = 32'h0000_0100,
    parameter int          INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc_in,
    input  logic            sys_call,
    input  logic            trap_ret,
    input  logic            lvl_wr,
    input  logic            lvl_wdata,
    output priv_lvl_e       lvl,
    output logic [PC_W-1:0] next_pc
);
    localparam logic [PC_W-1:0] ENTRY = ENTRY_ADDR[PC_W-1:0];
    localparam logic [PC_W-1:0] STEP  = PC_W'(INSN_BYTES);

    logic [PC_W-1:0] ret_addr;
    priv_lvl_e       ret_lvl;

    // Fetch address: entry on a call, stored address on a return, else the sequential PC.
    always_comb begin
        if (sys_call)
            next_pc = ENTRY;
        else if (trap_ret)
            next_pc = ret_addr;
        else
            next_pc = pc_in + STEP;
    end

    // Trap state: save on a call, reinstate on a return, take supervisor level writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl      <= LVL_SUP;
            ret_addr <= '0;
            ret_lvl  <= LVL_USER;
        end else if (sys_call) begin
            ret_addr <= pc_in;
            ret_lvl  <= lvl;
            lvl      <= LVL_SUP;
        end else if (trap_ret) begin
            lvl      <= ret_lvl;
        end else if (lvl_wr) begin
            lvl      <= priv_lvl_e'(lvl_wdata);
        end
    end

    a_r3_call_raises: assert property (@(posedge clk) disable iff (!rst_n)
        sys_call |=> lvl == LVL_SUP);
    a_r2_call_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
        sys_call |=> ret_addr == $past(pc_in));
    a_r3_call_saves_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        sys_call |=> ret_lvl == $past(lvl));
    a_r4_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !sys_call) |=> lvl == $past(ret_lvl));
endmodule

// File: rtl/pmc_guard.sv
// Module pmc_guard
// Decides whether a privileged write may proceed. Supervisor writes without a
// trap strobe are routed to one target. User-mode writes are refused and
// flagged for one cycle. Assumes writes during a trap strobe are dropped.
module pmc_guard
    import priv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pw_valid,
    input  pw_tgt_e   pw_sel,
    input  priv_lvl_e lvl,
    input  logic      trap_evt,
    output logic      wr_lvl,
    output logic      wr_exc,
    output logic      wr_prot,
    output logic      viol
);
    logic allowed;
    logic refused;

    // Permission: a write proceeds only from supervisor level with no trap strobe.
    always_comb begin
        allowed = pw_valid && !trap_evt && (lvl == LVL_SUP);
        refused = pw_valid && !trap_evt && (lvl == LVL_USER);
    end

    // Target decode: one enable per privileged field, none for the spare code.
    always_comb begin
        wr_lvl  = 1'b0;
        wr_exc  = 1'b0;
        wr_prot = 1'b0;
        if (allowed) begin
            unique case (pw_sel)
                TGT_LEVEL: wr_lvl  = 1'b1;
                TGT_EXC:   wr_exc  = 1'b1;
                TGT_PROT:  wr_prot = 1'b1;
                TGT_NONE:  ;
            endcase
        end
    end

    // Violation flag: registered one-cycle report of each refused write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol <= 1'b0;
        else
            viol <= refused;
    end

    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lvl, wr_exc, wr_prot}));
    a_r5_user_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_USER) |-> !(wr_lvl || wr_exc || wr_prot));
    a_r10_trap_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_evt |=> !viol);
endmodule

// File: rtl/pmc_ctrl_regs.sv
// Module pmc_ctrl_regs
// Stores the exception-enable bit and the protection-control field. Assumes
// the write enables have already been qualified by pmc_guard.
module pmc_ctrl_regs
    import priv_pkg::*;
#(
    parameter int PROT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  priv_lvl_e         lvl,
    input  logic              wr_exc,
    input  logic              wr_prot,
    input  logic [PROT_W-1:0] wdata,
    output logic              exc_en,
    output logic [PROT_W-1:0] prot
);
    // Control state: load each field on its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_en <= 1'b0;
            prot   <= '0;
        end else begin
            if (wr_exc)
                exc_en <= wdata[0];
            if (wr_prot)
                prot <= wdata;
        end
    end

    a_r5_user_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_USER) |=> $stable(exc_en) && $stable(prot));
endmodule

// File: rtl/priv_mode_ctrl.sv
// Module priv_mode_ctrl
// Top of the privilege controller: the trap unit, the write guard and the
// control registers. Assumes at most one instruction per cycle and pc_in
// valid in every cycle.
module priv_mode_ctrl
    import priv_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter int          PROT_W     = 4,
    parameter logic [31:0] ENTRY_ADDR = 32'h0000_0100,
    parameter int          INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              sys_call,
    input  logic              trap_ret,
    input  logic              pw_valid,
    input  logic [1:0]        pw_sel,
    input  logic [PROT_W-1:0] pw_data,
    output logic [PC_W-1:0]   next_pc,
    output logic              cur_mode,
    output logic              exc_en,
    output logic [PROT_W-1:0] prot_ctrl,
    output logic              priv_viol
);
    priv_lvl_e lvl;
    logic      wr_lvl;
    logic      wr_exc;
    logic      wr_prot;
    logic      trap_evt;

    // Trap strobe summary shared by the guard.
    always_comb trap_evt = sys_call || trap_ret;

    // Level export as a plain bit.
    always_comb cur_mode = lvl;

    pmc_trap_unit #(
        .PC_W       (PC_W),
        .ENTRY_ADDR (ENTRY_ADDR),
        .INSN_BYTES (INSN_BYTES)
    ) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_in     (pc_in),
        .sys_call  (sys_call),
        .trap_ret  (trap_ret),
        .lvl_wr    (wr_lvl),
        .lvl_wdata (pw_data[0]),
        .lvl       (lvl),
        .next_pc   (next_pc)
    );

    pmc_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .pw_valid (pw_valid),
        .pw_sel   (pw_tgt_e'(pw_sel)),
        .lvl      (lvl),
        .trap_evt (trap_evt),
        .wr_lvl   (wr_lvl),
        .wr_exc   (wr_exc),
        .wr_prot  (wr_prot),
        .viol     (priv_viol)
    );

    pmc_ctrl_regs #(
        .PROT_W (PROT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .wr_exc  (wr_exc),
        .wr_prot (wr_prot),
        .wdata   (pw_data),
        .exc_en  (exc_en),
        .prot    (prot_ctrl)
    );

    a_r6_viol_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> $stable(cur_mode) && $stable(exc_en) && $stable(prot_ctrl));
    a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_mode && !exc_en && (prot_ctrl == '0) && !priv_viol);
    a_r1_entry_on_call: assert property (@(posedge clk) disable iff (!rst_n)
        sys_call |-> next_pc == PC_W'(ENTRY_ADDR));
endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic        sys;
        logic        ret;
        logic        pw;
        logic [1:0]  sel;
        logic [3:0]  data;
        logic [31:0] pc;
        logic [31:0] xnpc;
        logic        xmode;
        logic        xviol;
        logic        xexc;
        logic [3:0]  xprot;
    } vec_t;

    // Walk from reset: sys ret pw sel data pc | next_pc mode viol exc prot
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,2'd2,4'hA,32'h1000, 32'h1004,1'b1,1'b0,1'b0,4'hA}, // R9 prot
        '{1'b0,1'b0,1'b1,2'd1,4'h1,32'h1004, 32'h1008,1'b1,1'b0,1'b1,4'hA}, // R9 exc
        '{1'b0,1'b1,1'b0,2'd0,4'h0,32'h1008, 32'h0000,1'b0,1'b0,1'b1,4'hA}, // R4 ret to reset state
        '{1'b0,1'b0,1'b1,2'd0,4'h1,32'h2000, 32'h2004,1'b0,1'b1,1'b1,4'hA}, // R5 R6 level
        '{1'b0,1'b0,1'b1,2'd1,4'h0,32'h2004, 32'h2008,1'b0,1'b1,1'b1,4'hA}, // R5 R6 exc
        '{1'b0,1'b0,1'b1,2'd2,4'h5,32'h2008, 32'h200C,1'b0,1'b1,1'b1,4'hA}, // R5 R6 prot
        '{1'b0,1'b0,1'b0,2'd0,4'h0,32'h200C, 32'h2010,1'b0,1'b0,1'b1,4'hA}, // R6 R10 idle
        '{1'b1,1'b0,1'b0,2'd0,4'h0,32'h2010, 32'h0100,1'b1,1'b0,1'b1,4'hA}, // R1 R3 call
        '{1'b1,1'b0,1'b0,2'd0,4'h0,32'h0104, 32'h0100,1'b1,1'b0,1'b1,4'hA}, // R3 nested
        '{1'b0,1'b1,1'b0,2'd0,4'h0,32'h0108, 32'h0104,1'b1,1'b0,1'b1,4'hA}, // R2 R4 ret
        '{1'b0,1'b0,1'b1,2'd0,4'h0,32'h0108, 32'h010C,1'b0,1'b0,1'b1,4'hA}, // R9 level
        '{1'b1,1'b1,1'b0,2'd0,4'h0,32'h3000, 32'h0100,1'b1,1'b0,1'b1,4'hA}, // R8 both
        '{1'b0,1'b1,1'b0,2'd0,4'h0,32'h0120, 32'h3000,1'b0,1'b0,1'b1,4'hA}, // R8 R2
        '{1'b1,1'b0,1'b1,2'd0,4'h0,32'h3004, 32'h0100,1'b1,1'b0,1'b1,4'hA}, // R10 drop
        '{1'b0,1'b1,1'b0,2'd0,4'h0,32'h0130, 32'h3004,1'b0,1'b0,1'b1,4'hA}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0;
    logic        sys_call = 1'b0;
    logic        trap_ret = 1'b0;
    logic        pw_valid = 1'b0;
    logic [1:0]  pw_sel = '0;
    logic [3:0]  pw_data = '0;
    logic [31:0] next_pc;
    logic        cur_mode;
    logic        exc_en;
    logic [3:0]  prot_ctrl;
    logic        priv_viol;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_mode_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_in     (pc_in),
        .sys_call  (sys_call),
        .trap_ret  (trap_ret),
        .pw_valid  (pw_valid),
        .pw_sel    (pw_sel),
        .pw_data   (pw_data),
        .next_pc   (next_pc),
        .cur_mode  (cur_mode),
        .exc_en    (exc_en),
        .prot_ctrl (prot_ctrl),
        .priv_viol (priv_viol)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic idle_inputs();
        sys_call = 1'b0; trap_ret = 1'b0; pw_valid = 1'b0; pw_sel = '0; pw_data = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 mode", 32'(cur_mode), 32'd1);
        check("R7 exc", 32'(exc_en), 32'd0);
        check("R7 prot", 32'(prot_ctrl), 32'd0);
        check("R7 viol", 32'(priv_viol), 32'd0);

        // Vector walk: next_pc in the cycle, state after the edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sys_call = VEC[i].sys; trap_ret = VEC[i].ret; pw_valid = VEC[i].pw;
            pw_sel = VEC[i].sel; pw_data = VEC[i].data; pc_in = VEC[i].pc;
            #1;
            check("R1 R2 R4 R8 R10 next_pc", next_pc, VEC[i].xnpc);
            @(posedge clk);
            #1;
            idle_inputs();
            check("R3 R4 R5 R9 mode", 32'(cur_mode), 32'(VEC[i].xmode));
            check("R6 viol", 32'(priv_viol), 32'(VEC[i].xviol));
            check("R5 R9 exc", 32'(exc_en), 32'(VEC[i].xexc));
            check("R5 R9 prot", 32'(prot_ctrl), 32'(VEC[i].xprot));
        end

        // Violation lasts one cycle (R6)
        @(negedge clk);
        check("R6 pulse ends", 32'(priv_viol), 32'd0);

        // Spare selector writes nothing (R9); mode is user here, so raise first
        sys_call = 1'b1; pc_in = 32'h4000;
        @(negedge clk);
        sys_call = 1'b0; pw_valid = 1'b1; pw_sel = 2'd3; pw_data = 4'hF;
        @(negedge clk);
        idle_inputs();
        check("R9 spare exc", 32'(exc_en), 32'd1);
        check("R9 spare prot", 32'(prot_ctrl), 32'hA);
        check("R9 spare mode", 32'(cur_mode), 32'd1);

        // Mid-run reset clears trap state (R7)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 mode after reset", 32'(cur_mode), 32'd1);
        check("R7 exc after reset", 32'(exc_en), 32'd0);
        check("R7 prot after reset", 32'(prot_ctrl), 32'd0);
        trap_ret = 1'b1; pc_in = 32'h5000;
        #1;
        check("R7 saved pc zero", next_pc, 32'h0);
        @(negedge clk);
        trap_ret = 1'b0;
        check("R7 saved level user", 32'(cur_mode), 32'd0);

        finish_run();
    end
endmodule